// File: doc/BRIEF.md
# Priority DCC Packet Scheduler

This block queues model-railway control packets and, once per scheduling tick, chooses at most one of them for the track transmitter. It keeps three ring queues. The urgent queue carries speed commands, the normal queue carries light and function commands, and the repeat queue carries packets that are sent again. On each tick the head of every queue is examined in a fixed order: urgent first, then normal, then repeat. The first head that is eligible goes to the transmitter's standby slot. A head is eligible when a newer packet has not made it stale and its locomotive address is not locked.

An enqueue makes every already queued packet with the same locomotive address and the same command kind stale. A packet placed in the urgent or normal queue is also copied three times into the repeat queue. After a packet is sent, its address stays locked for five ticks. If a pass finds nothing eligible, the block raises a one-cycle repeat request so that the surrounding control logic can refresh locomotive states. When the `no_locos` input also reports an empty roster, the block sends a fixed idle packet instead, so that decoders on the track do not drop into analog mode.

Enqueue is a valid/ready stream. A beat transfers on a clock edge where both `enq_valid` and `enq_ready` are high. `enq_ready` depends only on queue occupancy and `enq_queue`, never on `enq_valid`. A producer may hold `enq_valid` high through back-pressure. On the transmit side, `tx_ready` reports that the standby slot is empty, and `tx_valid` pulses for one cycle when a packet is handed over. Queue depth must be a power of two.

Top module: `pkt_sched`

## Requirements
- R1: Among the queue heads that are eligible, the urgent queue (`enq_queue` = 0) wins over the normal queue (1), and the normal queue wins over the repeat queue (2). Code 3 is never accepted.
- R2: A handover happens only on a tick while `tx_ready` is high. At most one packet is handed over per tick. `tx_valid` and `tx_data` appear in the cycle after the tick.
- R3: After a packet is handed over on tick t, no packet for the same address is handed over on ticks t+1 to t+4. A packet for that address waiting at a head is handed over on tick t+5.
- R4: An accepted enqueue makes stale every packet, in all three queues, that has the same address and command kind. Packets with a different command kind for that address stay live.
- R5: On a tick, each queue whose head is stale drops that head without sending it, whatever the state of `tx_ready`. A stale head never counts as eligible.
- R6: An accepted urgent or normal enqueue adds one entry to its own queue and three copies to the repeat queue. An enqueue aimed at the repeat queue adds one entry there.
- R7: `rep_req` pulses in the cycle after any tick on which no queue head was eligible.
- R8: When no head is eligible, `no_locos` is high and `tx_ready` is high, the tick hands over the idle packet 32'hFF00FF00. `rep_req` is raised on that tick as well.
- R9: `enq_ready` is low when the target queue is full. It is also low for an urgent or normal enqueue when the repeat queue has fewer than three free entries. A refused beat adds nothing to any queue, and `enq_ovf` is high in the next cycle.
- R10: After reset all queues and locks are empty, and `tx_valid`, `rep_req` and `enq_ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Scheduling pass enable, one cycle per millisecond |
| enq_valid | input | 1 | Enqueue beat valid |
| enq_ready | output | 1 | Enqueue beat can be taken |
| enq_queue | input | 2 | Target queue: 0 urgent, 1 normal, 2 repeat |
| enq_addr | input | 8 | Locomotive address |
| enq_cmd | input | 2 | Command kind |
| enq_data | input | 32 | Packet bytes |
| tx_ready | input | 1 | Transmitter standby slot is empty |
| tx_valid | output | 1 | Packet handed to standby slot (one-cycle pulse) |
| tx_data | output | 32 | Packet bytes handed over |
| no_locos | input | 1 | No locomotives are registered |
| rep_req | output | 1 | Nothing was eligible on the last tick |
| enq_ovf | output | 1 | An enqueue beat was refused in the previous cycle |

## Verification
The first pattern uses two packets for different addresses in the urgent and normal queues. It separates priority order from lock gating, because the repeat copies then drain at exactly five-tick spacing. The second pattern enqueues the same address and command kind twice, once within the repeat queue and once across the normal and urgent queues. This separates stale marking and head dropping from plain FIFO order. It also shows that a different command kind for the same address stays live but is still lock-gated. Further passes hold `tx_ready` low, raise `no_locos` on empty queues, and fill the repeat queue until back-pressure appears. These passes separate slot gating, idle injection and refusal without side effects.

// File: rtl/pkt_sched_pkg.sv
package pkt_sched_pkg;
  localparam int ADDR_W     = 8;
  localparam int CMD_W      = 2;
  localparam int PKT_W      = 32;
  localparam int NQ         = 3;
  localparam int REP_COPIES = 3;
  localparam logic [PKT_W-1:0] IDLE_PKT = 32'hFF00_FF00;

  typedef enum logic [1:0] {
    Q_HI  = 2'd0,
    Q_LO  = 2'd1,
    Q_REP = 2'd2
  } qsel_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CMD_W-1:0]  cmd;
    logic [PKT_W-1:0]  data;
  } pkt_t;
endpackage

// File: rtl/pkt_ring.sv
module pkt_ring
  import pkt_sched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int MAXP  = 3,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(MAXP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NW-1:0]     push_n,
  input  pkt_t              push_pkt,
  input  logic              pop,
  input  logic              mark_en,
  input  logic [ADDR_W-1:0] mark_addr,
  input  logic [CMD_W-1:0]  mark_cmd,
  output logic              head_vld,
  output pkt_t              head_pkt,
  output logic              head_obs,
  output logic [CW-1:0]     free_cnt
);
  pkt_t             mem [DEPTH];
  logic [DEPTH-1:0] obs;
  logic [PW-1:0]    rp, wp;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk) begin
    for (int k = 0; k < MAXP; k++)
      if (NW'(k) < push_n) mem[wp + PW'(k)] <= push_pkt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
      obs <= '0;
    end else begin
      if (mark_en)
        for (int i = 0; i < DEPTH; i++)
          if (mem[i].addr == mark_addr && mem[i].cmd == mark_cmd) obs[i] <= 1'b1;
      for (int k = 0; k < MAXP; k++)
        if (NW'(k) < push_n) obs[wp + PW'(k)] <= 1'b0;
      wp  <= wp + PW'(push_n);
      rp  <= rp + PW'(pop);
      cnt <= cnt + CW'(push_n) - CW'(pop);
    end
  end

  assign head_vld = (cnt != '0);
  assign head_pkt = mem[rp];
  assign head_obs = obs[rp];
  assign free_cnt = CW'(DEPTH) - cnt;
endmodule

// File: rtl/addr_lock.sv
module addr_lock
  import pkt_sched_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int TICKS = 5,
  parameter int NLOOK = 3,
  localparam int TW = $clog2(TICKS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic [NLOOK-1:0][ADDR_W-1:0] look_addr,
  output logic [NLOOK-1:0]             locked,
  input  logic                         set_en,
  input  logic [ADDR_W-1:0]            set_addr
);
  logic [ADDR_W-1:0] la [SLOTS];
  logic [TW-1:0]     lc [SLOTS];
  logic [SLOTS-1:0]  pick;
  logic              found;

  always_comb begin
    for (int q = 0; q < NLOOK; q++) begin
      locked[q] = 1'b0;
      for (int s = 0; s < SLOTS; s++)
        if (lc[s] != '0 && la[s] == look_addr[q]) locked[q] = 1'b1;
    end
  end

  // first idle slot takes a new lock
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int s = 0; s < SLOTS; s++)
      if (!found && lc[s] == '0) begin
        pick[s] = 1'b1;
        found   = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) begin
        la[s] <= '0;
        lc[s] <= '0;
      end
    end else if (tick) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (set_en && pick[s]) begin
          la[s] <= set_addr;
          lc[s] <= TW'(TICKS - 1);
        end else if (lc[s] != '0) begin
          lc[s] <= lc[s] - TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pick_arb.sv
module pick_arb #(
  parameter int NQ = 3
) (
  input  logic [NQ-1:0] vld,
  input  logic [NQ-1:0] obs,
  input  logic [NQ-1:0] lck,
  input  logic          tx_ready,
  input  logic          no_locos,
  output logic [NQ-1:0] grant,
  output logic [NQ-1:0] drop,
  output logic          none_elig,
  output logic          idle_go
);
  logic [NQ-1:0] elig;
  logic          taken;

  assign elig = vld & ~obs & ~lck;
  assign drop = vld & obs;

  // lowest index has highest priority
  always_comb begin
    grant = '0;
    taken = 1'b0;
    for (int q = 0; q < NQ; q++)
      if (!taken && elig[q]) begin
        grant[q] = tx_ready;
        taken    = 1'b1;
      end
  end

  assign none_elig = ~|elig;
  assign idle_go   = none_elig & no_locos & tx_ready;
endmodule

// File: rtl/pkt_sched.sv
module pkt_sched
  import pkt_sched_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int LOCK_SLOTS = 8,
  parameter int LOCK_TICKS = 5,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [1:0]        enq_queue,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic [CMD_W-1:0]  enq_cmd,
  input  logic [PKT_W-1:0]  enq_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [PKT_W-1:0]  tx_data,
  input  logic              no_locos,
  output logic              rep_req,
  output logic              enq_ovf
);
  logic [NQ-1:0][1:0]        push_n;
  pkt_t [NQ-1:0]             q_head;
  logic [NQ-1:0]             h_vld, h_obs, lck, grant, drop, pop;
  logic [NQ-1:0][CW-1:0]     free_c;
  logic [NQ-1:0][ADDR_W-1:0] look_addr;
  logic                      none_elig, idle_go, enq_fire, set_en;
  pkt_t                      in_pkt, win_pkt;

  assign in_pkt = '{addr: enq_addr, cmd: enq_cmd, data: enq_data};

  always_comb begin
    unique case (enq_queue)
      Q_HI:    enq_ready = (free_c[0] != '0) && (free_c[2] >= CW'(REP_COPIES));
      Q_LO:    enq_ready = (free_c[1] != '0) && (free_c[2] >= CW'(REP_COPIES));
      Q_REP:   enq_ready = (free_c[2] != '0);
      default: enq_ready = 1'b0;
    endcase
  end
  assign enq_fire = enq_valid & enq_ready;
  assign pop      = {NQ{tick}} & (grant | drop);

  for (genvar g = 0; g < NQ; g++) begin : g_q
    if (g == int'(Q_REP)) begin : g_rep
      assign push_n[g] = !enq_fire ? 2'd0 :
                         (enq_queue == Q_REP) ? 2'd1 : 2'(REP_COPIES);
    end else begin : g_pri
      assign push_n[g] = (enq_fire && enq_queue == 2'(g)) ? 2'd1 : 2'd0;
    end

    pkt_ring #(.DEPTH(DEPTH), .MAXP(REP_COPIES)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_n   (push_n[g]),
      .push_pkt (in_pkt),
      .pop      (pop[g]),
      .mark_en  (enq_fire),
      .mark_addr(enq_addr),
      .mark_cmd (enq_cmd),
      .head_vld (h_vld[g]),
      .head_pkt (q_head[g]),
      .head_obs (h_obs[g]),
      .free_cnt (free_c[g])
    );
    assign look_addr[g] = q_head[g].addr;
  end

  pick_arb #(.NQ(NQ)) u_arb (
    .vld      (h_vld),
    .obs      (h_obs),
    .lck      (lck),
    .tx_ready (tx_ready),
    .no_locos (no_locos),
    .grant    (grant),
    .drop     (drop),
    .none_elig(none_elig),
    .idle_go  (idle_go)
  );

  always_comb begin
    win_pkt = '0;
    for (int q = 0; q < NQ; q++)
      if (grant[q]) win_pkt = q_head[q];
  end
  assign set_en = tick & (|grant);

  addr_lock #(.SLOTS(LOCK_SLOTS), .TICKS(LOCK_TICKS), .NLOOK(NQ)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .look_addr(look_addr),
    .locked   (lck),
    .set_en   (set_en),
    .set_addr (win_pkt.addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      rep_req  <= 1'b0;
      enq_ovf  <= 1'b0;
    end else begin
      tx_valid <= tick & ((|grant) | idle_go);
      if (tick && (|grant)) tx_data <= win_pkt.data;
      else if (tick && idle_go) tx_data <= IDLE_PKT;
      rep_req  <= tick & none_elig;
      enq_ovf  <= enq_valid & ~enq_ready;
    end
  end
endmodule

// File: rtl/pkt_sched_chk.sv
module pkt_sched_chk
  import pkt_sched_pkg::*;
#(
  parameter int NQC = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             tx_ready,
  input logic             tx_valid,
  input logic [PKT_W-1:0] tx_data,
  input logic             rep_req,
  input logic             enq_valid,
  input logic             enq_ready,
  input logic             enq_ovf,
  input logic [NQC-1:0]   grant
);
  // R2
  tx_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ($past(tick) && $past(tx_ready)));

  // R1
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R9
  refuse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !enq_ready) |=> enq_ovf);

  // R8
  idle_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_req && tx_valid) |-> (tx_data == IDLE_PKT));

  // R7
  rep_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_req |-> $past(tick));
endmodule

bind pkt_sched pkt_sched_chk #(.NQC(pkt_sched_pkg::NQ)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .tx_ready (tx_ready),
  .tx_valid (tx_valid),
  .tx_data  (tx_data),
  .rep_req  (rep_req),
  .enq_valid(enq_valid),
  .enq_ready(enq_ready),
  .enq_ovf  (enq_ovf),
  .grant    (grant)
);

// File: tb/sim_pkt_sched.sv
`timescale 1ns/1ps
module sim_pkt_sched;
  import pkt_sched_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, enq_valid = 1'b0;
  logic enq_ready, tx_valid, rep_req, enq_ovf;
  logic [1:0]        enq_queue = 2'd0;
  logic [ADDR_W-1:0] enq_addr = '0;
  logic [CMD_W-1:0]  enq_cmd = '0;
  logic [PKT_W-1:0]  enq_data = '0;
  logic [PKT_W-1:0]  tx_data;
  logic tx_ready = 1'b1, no_locos = 1'b0;

  int n_chk = 0, n_bad = 0, tick_no = 0;
  logic [PKT_W-1:0] exp_data[$];
  int               exp_tick[$];
  string            exp_tag[$];

  always #10 clk = ~clk;

  pkt_sched u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_queue(enq_queue), .enq_addr(enq_addr), .enq_cmd(enq_cmd), .enq_data(enq_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .no_locos(no_locos),
    .rep_req(rep_req), .enq_ovf(enq_ovf)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [PKT_W-1:0] act, input logic [PKT_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a packet is handed over
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (exp_data.size() == 0) begin
        check(1'b0, "R2", "unexpected handover", tx_data, '0);
      end else begin
        automatic logic [PKT_W-1:0] d = exp_data.pop_front();
        automatic int t = exp_tick.pop_front();
        automatic string g = exp_tag.pop_front();
        check(tx_data == d, g, "handover data", tx_data, d);
        check(tick_no == t, g, "handover tick", tick_no, t);
      end
    end
  end

  task automatic enq(input logic [1:0] q, input int a, input int c, input logic [PKT_W-1:0] d,
                     input bit exp_rdy, input string tag);
    @(negedge clk);
    enq_queue = q; enq_addr = ADDR_W'(a); enq_cmd = CMD_W'(c); enq_data = d; enq_valid = 1'b1;
    #1 check(enq_ready == exp_rdy, tag, "enq_ready", enq_ready, exp_rdy);
    @(posedge clk);
    #1 enq_valid = 1'b0;
    check(enq_ovf == !exp_rdy, tag, "enq_ovf", enq_ovf, !exp_rdy);
  endtask

  task automatic tk(input bit send, input logic [PKT_W-1:0] d, input bit exp_rep, input string tag);
    @(negedge clk);
    tick_no++;
    if (send) begin
      exp_data.push_back(d); exp_tick.push_back(tick_no); exp_tag.push_back(tag);
    end
    tick = 1'b1;
    @(posedge clk);
    #1 tick = 1'b0;
    @(negedge clk);
    check(rep_req == exp_rep, tag, "rep_req", rep_req, exp_rep);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(tx_valid == 1'b0, "R10", "tx_valid", tx_valid, 0);
    check(rep_req == 1'b0, "R10", "rep_req", rep_req, 0);
    check(enq_ovf == 1'b0, "R10", "enq_ovf", enq_ovf, 0);
    check(enq_ready == 1'b1, "R10", "enq_ready", enq_ready, 1);

    // priority, repeat copies and lock spacing
    enq(Q_LO, 2, 1, 32'h0000_0A11, 1'b1, "R6");
    enq(Q_HI, 1, 0, 32'h0000_0B22, 1'b1, "R6");
    for (int k = 1; k <= 28; k++) begin
      case (k)
        1:          tk(1'b1, 32'h0000_0B22, 1'b0, "R1");
        2:          tk(1'b1, 32'h0000_0A11, 1'b0, "R1");
        7, 12, 17:  tk(1'b1, 32'h0000_0A11, 1'b0, "R6");
        18, 23, 28: tk(1'b1, 32'h0000_0B22, 1'b0, "R3");
        default:    tk(1'b0, '0, 1'b1, "R3");
      endcase
    end

    // stale marking inside the repeat queue
    enq(Q_REP, 4, 2, 32'h0000_0401, 1'b1, "R4");
    enq(Q_REP, 4, 2, 32'h0000_0402, 1'b1, "R4");
    tk(1'b0, '0, 1'b1, "R5");
    tk(1'b1, 32'h0000_0402, 1'b0, "R4");
    // different command kind survives but is lock gated
    enq(Q_REP, 5, 1, 32'h0000_0501, 1'b1, "R4");
    enq(Q_REP, 5, 2, 32'h0000_0502, 1'b1, "R4");
    tk(1'b1, 32'h0000_0501, 1'b0, "R4");
    for (int k = 0; k < 4; k++) tk(1'b0, '0, 1'b1, "R3");
    tk(1'b1, 32'h0000_0502, 1'b0, "R3");

    // stale marking across normal and repeat queues
    enq(Q_LO, 7, 1, 32'h0000_0701, 1'b1, "R4");
    enq(Q_HI, 7, 1, 32'h0000_0702, 1'b1, "R4");
    for (int k = 1; k <= 16; k++) begin
      case (k)
        1:          tk(1'b1, 32'h0000_0702, 1'b0, "R5");
        2, 3:       tk(1'b0, '0, 1'b1, "R5");
        6, 11, 16:  tk(1'b1, 32'h0000_0702, 1'b0, "R3");
        default:    tk(1'b0, '0, 1'b1, "R3");
      endcase
    end

    // standby slot busy
    tx_ready = 1'b0;
    enq(Q_REP, 6, 0, 32'h0000_0601, 1'b1, "R2");
    tk(1'b0, '0, 1'b0, "R2");
    tx_ready = 1'b1;
    tk(1'b1, 32'h0000_0601, 1'b0, "R2");

    // idle injection
    no_locos = 1'b1;
    tk(1'b1, IDLE_PKT, 1'b1, "R8");
    tx_ready = 1'b0;
    tk(1'b0, '0, 1'b1, "R8");
    tx_ready = 1'b1;
    no_locos = 1'b0;
    tk(1'b0, '0, 1'b1, "R7");

    // fill the repeat queue and refuse more
    tx_ready = 1'b0;
    for (int i = 0; i < 8; i++) enq(Q_REP, 20 + i, 0, PKT_W'(32'h0000_2000 + i), 1'b1, "R9");
    enq(Q_REP, 40, 0, 32'h0000_DEAD, 1'b0, "R9");
    enq(Q_HI, 41, 0, 32'h0000_BEEF, 1'b0, "R9");
    tx_ready = 1'b1;
    for (int i = 0; i < 8; i++) tk(1'b1, PKT_W'(32'h0000_2000 + i), 1'b0, "R9");
    tk(1'b0, '0, 1'b1, "R9");

    repeat (4) @(negedge clk);
    check(exp_data.size() == 0, "R2", "missing handovers", exp_data.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule